// File: doc/BRIEF.md
# Bit-Sliced Ripple Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit assembled from identical one-bit slices. Each slice holds a full adder, an AND gate, an OR gate, a conditional inverter on its second operand and a four-way selector. Carries travel from the lowest slice to the highest. A single negate input controls two things at once: it inverts operand B in every slice, and it supplies the carry into bit 0. With negate asserted the adder computes a plus the two's complement of b.

The top slice is a variant of the common slice. It also exposes its raw sum bit as a set signal and it detects signed overflow. The set signal is routed back to the less-than input of bit 0, so a set-on-less-than operation returns 0 or 1 in the lowest result bit. A zero flag reports an all-zero result, which lets an equality test be done by subtracting and checking that flag.

Top module: `rip_alu`

## Requirements
- R1: With negate_i = 0 and op_i = 2'b00, result_o equals a_i AND b_i bit by bit.
- R2: With negate_i = 0 and op_i = 2'b01, result_o equals a_i OR b_i bit by bit.
- R3: With negate_i = 0 and op_i = 2'b10, result_o is the low 32 bits of a_i + b_i, and carry_o is bit 32 of that sum.
- R4: With negate_i = 1 and op_i = 2'b10, result_o is (a_i - b_i) mod 2^32, and carry_o is 1 exactly when a_i >= b_i taken as unsigned.
- R5: With negate_i = 1 and op_i = 2'b11, result_o[31:1] is 0. result_o[0] is bit 31 of (a_i - b_i) mod 2^32, with no overflow correction, so a_i = 0x80000000 with b_i = 1 gives 0.
- R6: zero_o is 1 exactly when every bit of result_o is 0, for every operation. A subtraction of equal operands therefore sets it.
- R7: For add and subtract, overflow_o is 1 exactly when a_i and the effective second operand (b_i, or ~b_i when negating) have the same bit 31 and result_o[31] differs from it.
- R8: The inversion applies to the logic operations as well. With negate_i = 1, op_i = 2'b00 gives a_i AND NOT b_i, and op_i = 2'b01 gives a_i OR NOT b_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| negate_i | input | 1 | Inverts B in every slice and sets the carry into bit 0 |
| op_i | input | 2 | Selector: 00 AND, 01 OR, 10 sum, 11 less-than |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow from the top slice |
| carry_o | output | 1 | Carry out of the top slice |

## Verification
The block holds no state, so a broken carry link, a missing inversion or a mis-wired less input appears on the ports in the same cycle the operands are applied. A break in the carry chain is visible only for operands whose carries run through the broken bit, so the vectors include all-ones, the most negative value and long carry runs. A defect in the set feedback shows up only on less-than results and on overflowing less-than cases, where the expected answer is deliberately the uncorrected one.

// File: rtl/alu_pkg.sv
// Shared definitions for the ripple ALU.
// Assumes a two-bit operation selector whose codes are decoded by every slice.
package alu_pkg;

    // Operation selector codes seen by each slice multiplexer
    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_SUM  = 2'b10,
        OP_LESS = 2'b11
    } alu_op_e;

endpackage

// File: rtl/alu_slice.sv
// One bit of the ALU: conditional B inversion, AND, OR, full adder and a
// four-way output selector. When IS_MSB is set, the slice also exports its
// raw sum as the set signal and flags signed overflow. Otherwise both of
// those outputs are held at 0 so that the parent can OR-reduce them.
// Assumes that the carry and less inputs settle before the output is used.
module alu_slice
    import alu_pkg::*;
#(
    parameter bit IS_MSB = 1'b0
) (
    input  logic    a_i,
    input  logic    b_i,
    input  logic    binv_i,
    input  logic    cin_i,
    input  logic    less_i,
    input  alu_op_e op_i,
    output logic    res_o,
    output logic    cout_o,
    output logic    set_o,
    output logic    ovf_o
);

    logic b_eff;
    logic half;
    logic sum;

    // Conditional inversion of the second operand
    assign b_eff  = binv_i ? ~b_i : b_i;
    // Full adder built from a half sum and a carry
    assign half   = a_i ^ b_eff;
    assign sum    = half ^ cin_i;
    assign cout_o = (a_i & b_eff) | (cin_i & half);

    // Output selector driven by the operation code
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_eff;
            OP_OR:   res_o = a_i | b_eff;
            OP_SUM:  res_o = sum;
            default: res_o = less_i;
        endcase
    end

    // Top-slice extras: raw sign feedback and overflow detection
    if (IS_MSB) begin : g_top
        assign set_o = sum;
        assign ovf_o = cin_i ^ cout_o;
    end else begin : g_body
        assign set_o = 1'b0;
        assign ovf_o = 1'b0;
    end

endmodule

// File: rtl/alu_zero_detect.sv
// Flags an all-zero result word. Purely combinational.
// Assumes WIDTH >= 1.
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             zero_o
);

    // Reduction NOR across the whole word
    assign zero_o = ~(|word_i);

endmodule

// File: rtl/rip_alu.sv
// Ripple-carry ALU made of WIDTH one-bit slices produced by a generate loop.
// negate_i drives both the B inversion and the carry into bit 0. The top
// slice returns its sum sign to the less input of bit 0 for set-on-less-than.
// Assumes WIDTH >= 2. The flags carry_o and overflow_o are meaningful only
// for the sum operation.
module rip_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             negate_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             overflow_o,
    output logic             carry_o
);

    localparam int MSB = WIDTH - 1;

    alu_op_e          op_e;
    logic [WIDTH-1:0] res_v;
    logic [WIDTH-1:0] set_v;
    logic [WIDTH-1:0] ovf_v;
    logic             set_w;

    // Decode the raw selector into the shared enum
    assign op_e  = alu_op_e'(op_i);
    // Only the top slice drives non-zero set and overflow bits
    assign set_w = |set_v;

    // Slice chain with ripple carries between neighbours
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic cin_w;
        logic cout_w;
        logic less_w;

        if (i == 0) begin : g_lsb
            assign cin_w  = negate_i;
            assign less_w = set_w;
        end else begin : g_up
            assign cin_w  = g_bit[i-1].cout_w;
            assign less_w = 1'b0;
        end

        alu_slice #(
            .IS_MSB (i == MSB)
        ) u_slice (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .binv_i (negate_i),
            .cin_i  (cin_w),
            .less_i (less_w),
            .op_i   (op_e),
            .res_o  (res_v[i]),
            .cout_o (cout_w),
            .set_o  (set_v[i]),
            .ovf_o  (ovf_v[i])
        );
    end

    // Collect the outputs of the chain
    assign result_o   = res_v;
    assign carry_o    = g_bit[MSB].cout_w;
    assign overflow_o = |ovf_v;

    alu_zero_detect #(
        .WIDTH (WIDTH)
    ) u_zero (
        .word_i (res_v),
        .zero_o (zero_o)
    );

    // Cross-check the slice chain against word-level arithmetic
    always_comb begin
        if (!negate_i && op_e == OP_SUM) begin
            // R3
            add_sum_chk: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}));
        end
        if (negate_i && op_e == OP_SUM) begin
            // R4
            sub_diff_chk: assert (result_o == (a_i - b_i) && carry_o == (a_i >= b_i));
            // R6
            zero_eq_chk: assert (zero_o == (a_i == b_i));
            // R7
            sub_ovf_chk: assert (overflow_o == ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])));
        end
        if (!negate_i && op_e == OP_SUM) begin
            // R7
            add_ovf_chk: assert (overflow_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])));
        end
        if (op_e == OP_LESS) begin
            // R5
            slt_upper_chk: assert (result_o[MSB:1] == '0);
        end
    end

endmodule

// File: tb/rip_alu_tb.sv
// Self-checking bench: a table of directed vectors, then operand corner
// pairs and random operands compared against a word-level reference.
module rip_alu_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         neg;
    logic [1:0]   op;
    logic [W-1:0] res;
    logic         zero;
    logic         ovf;
    logic         cout;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rip_alu #(.WIDTH(W)) u_dut (
        .a_i        (a),
        .b_i        (b),
        .negate_i   (neg),
        .op_i       (op),
        .result_o   (res),
        .zero_o     (zero),
        .overflow_o (ovf),
        .carry_o    (cout)
    );

    // Directed table: {a, b, negate, op, expected result}
    localparam int NV = 9;
    localparam logic [98:0] VEC [NV] = '{
        {32'hFFFF0000, 32'h0F0F0F0F, 1'b0, 2'b00, 32'h0F0F0000},
        {32'hFFFF0000, 32'h0F0F0F0F, 1'b0, 2'b01, 32'hFFFF0F0F},
        {32'h7FFFFFFF, 32'h00000001, 1'b0, 2'b10, 32'h80000000},
        {32'h00000005, 32'h00000007, 1'b1, 2'b10, 32'hFFFFFFFE},
        {32'h00000005, 32'h00000007, 1'b1, 2'b11, 32'h00000001},
        {32'h80000000, 32'h00000001, 1'b1, 2'b11, 32'h00000000},
        {32'h12345678, 32'h12345678, 1'b1, 2'b10, 32'h00000000},
        {32'hF0F0F0F0, 32'h0FF00FF0, 1'b1, 2'b00, 32'hF000F000},
        {32'h00000000, 32'hFFFFFFFF, 1'b1, 2'b01, 32'h00000000}
    };

    // Word-level reference: {overflow, carry, result}
    function automatic logic [W+1:0] ref_alu(logic [W-1:0] ra, logic [W-1:0] rb,
                                             logic rn, logic [1:0] ro);
        logic [W-1:0] be;
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         v;
        be = rn ? ~rb : rb;
        s  = {1'b0, ra} + {1'b0, be} + {{W{1'b0}}, rn};
        case (ro)
            2'b00:   r = ra & be;
            2'b01:   r = ra | be;
            2'b10:   r = s[W-1:0];
            default: r = {{(W-1){1'b0}}, s[W-1]};
        endcase
        v = (ra[W-1] == be[W-1]) && (s[W-1] != ra[W-1]);
        return {v, s[W], r};
    endfunction

    function automatic string tag_of(logic rn, logic [1:0] ro);
        if (ro == 2'b10) return rn ? "R4" : "R3";
        if (ro == 2'b11) return "R5";
        if (rn)          return "R8";
        return (ro == 2'b00) ? "R1" : "R2";
    endfunction

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: a=%h b=%h neg=%b op=%b actual=%h expected=%h",
                     tag, what, a, b, neg, op, act, exp);
        end
    endtask

    // Drive one operation, sample on the falling edge, and compare all outputs that apply
    task automatic apply(logic [W-1:0] ta, logic [W-1:0] tb_, logic tn, logic [1:0] to);
        logic [W+1:0] e;
        @(posedge clk);
        a = ta; b = tb_; neg = tn; op = to;
        @(negedge clk);
        e = ref_alu(ta, tb_, tn, to);
        check(tag_of(tn, to), "result", res, e[W-1:0]);
        check("R6", "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (e[W-1:0] == '0)});
        if (to == 2'b10) begin
            check(tag_of(tn, to), "carry", {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, e[W]});
            check("R7", "overflow", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, e[W+1]});
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] corners [5];
        logic [W+1:0] e;
        corners = '{32'h0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h1};
        a = '0; b = '0; neg = 1'b0; op = 2'b00;

        // Idle state with zero operands while reset is held
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "idle result", res, '0);
        check("R6", "idle zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
        rst_n = 1'b1;

        // Directed table: results against stored values, flags against the reference
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            a = VEC[i][98:67]; b = VEC[i][66:35]; neg = VEC[i][34]; op = VEC[i][33:32];
            @(negedge clk);
            e = ref_alu(a, b, neg, op);
            check(tag_of(neg, op), "table result", res, VEC[i][31:0]);
            check("R6", "table zero", {{(W-1){1'b0}}, zero},
                  {{(W-1){1'b0}}, (VEC[i][31:0] == '0)});
            if (op == 2'b10)
                check("R7", "table overflow", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, e[W+1]});
        end

        // Corner operand pairs under every defined operation
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++) begin
                apply(corners[i], corners[j], 1'b0, 2'b00);
                apply(corners[i], corners[j], 1'b0, 2'b01);
                apply(corners[i], corners[j], 1'b0, 2'b10);
                apply(corners[i], corners[j], 1'b1, 2'b10);
                apply(corners[i], corners[j], 1'b1, 2'b11);
                apply(corners[i], corners[j], 1'b1, 2'b00);
                apply(corners[i], corners[j], 1'b1, 2'b01);
            end

        // R6: equality test through subtraction of equal operands
        apply(32'hDEADBEEF, 32'hDEADBEEF, 1'b1, 2'b10);
        // R5: overflowing less-than returns the uncorrected sign
        apply(32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1, 2'b11);
        // R4: borrow case, carry out low
        apply(32'h00000001, 32'h00000002, 1'b1, 2'b10);

        // Random operands under every defined operation
        void'($urandom(32'h5EED));
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = $urandom;
            rb = (k % 10 == 0) ? ra : $urandom;
            apply(ra, rb, 1'b0, 2'b00);
            apply(ra, rb, 1'b0, 2'b01);
            apply(ra, rb, 1'b0, 2'b10);
            apply(ra, rb, 1'b1, 2'b10);
            apply(ra, rb, 1'b1, 2'b11);
            apply(ra, rb, 1'b1, 2'b00);
            apply(ra, rb, 1'b1, 2'b01);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule